// File: doc/BRIEF.md
# Floating-point condition-code branch and conditional-move evaluator

This block sits beside a floating-point register file and decides two things from an 8-bit vector of floating-point condition flags: whether a condition-code branch is taken, and which 64-bit value a conditional move writes back. A 64-bit register value is handled either as one whole word or as two independent 32-bit halves (paired mode). A 3-bit index picks the first flag to test. Branches can test one, two or four consecutive flags at once. The result is produced by combinational logic and captured in a single output register stage.

The inputs are the flag vector, the index and a 4-bit operation code. There is also a general-register value, used for the zero and non-zero tests and for the paired align operation. The remaining inputs are two source values and the old destination value. The outputs are a taken bit, a 64-bit write-back value, and a valid bit. The valid bit comes from a two-state output stage. `ST_EMPTY` goes to `ST_FULL` when `in_valid` is high. `ST_FULL` stays in `ST_FULL` while `in_valid` stays high and returns to `ST_EMPTY` when it drops. Reset forces `ST_EMPTY`. The endianness of the align operation is a parameter.

Top module: `fcc_move_branch`

## Requirements
- R1: Single-flag branches test flag `cc_idx`. Op 0 (false form) is taken when that flag is 0. Op 3 (true form) is taken when it is 1.
- R2: Group branches test a window of flags starting at `cc_idx`. Ops 1 and 4 use a window of 2 flags, and ops 2 and 5 use a window of 4. The false forms (ops 1, 2) are taken if any flag in the window is 0. The true forms (ops 4, 5) are taken if any flag in the window is 1.
- R3: A flag position above 7 that falls inside a window reads as 0. This holds for branches and for the upper half of paired moves.
- R4: Paired moves treat the two halves independently. The lower half [31:0] is controlled by flag `cc_idx` and the upper half [63:32] by flag `cc_idx+1`. Op 10 copies a half from `src_a` where its flag is 0. Op 11 copies where its flag is 1. Every other half keeps `dst_old`.
- R5: Op 6 copies all of `src_a` when flag `cc_idx` is 0, and op 7 copies it when the flag is 1; otherwise the result is `dst_old`. Ops 8 and 9 use the same two tests but replace only the lower half, and the upper half always keeps `dst_old`.
- R6: Op 12 writes all of `src_a` when `gpr` equals zero. Op 13 writes all of `src_a` when `gpr` is nonzero. In every other case the result is `dst_old`.
- R7: Op 14 (align) decodes `gpr[2:0]`. Value 0 gives `src_a`. Value 4 gives a result built from one half of each source: `{src_a[31:0], src_b[63:32]}` when BIG_ENDIAN=1, or `{src_b[31:0], src_a[63:32]}` when BIG_ENDIAN=0. Any other value gives `dst_old`.
- R8: The result is registered. `out_valid`, `taken` and `wr_data` reflect the inputs presented on the previous rising edge at which `in_valid` was 1. Reset clears all three to 0. `out_valid` falls one cycle after `in_valid` falls, and `wr_data` holds its value meanwhile.
- R9: Branch ops write back `dst_old`. Non-branch ops (6 to 15) never assert `taken`. Op 15 returns `dst_old`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| op | input | 4 | Operation code (see requirements) |
| cc_vec | input | 8 | Floating-point condition flags |
| cc_idx | input | 3 | Index of the first flag tested |
| gpr | input | 64 | General-register value for zero tests and align |
| src_a | input | 64 | First source value |
| src_b | input | 64 | Second source value (align only) |
| dst_old | input | 64 | Current destination value |
| out_valid | output | 1 | Registered result is valid |
| taken | output | 1 | Registered branch decision |
| wr_data | output | 64 | Registered write-back value |

## Verification
The clocked properties compare each registered result with the inputs one cycle earlier. They assume that whenever `out_valid` is high, the previous cycle carried `in_valid` together with stable inputs. The stimulus therefore changes all inputs together, only between clock edges, and holds `in_valid` high for the whole table walk. The properties also assume that the op code is a defined value. The table uses only the sixteen documented codes.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [3:0] {
        OP_BF1 = 4'd0,
        OP_BF2 = 4'd1,
        OP_BF4 = 4'd2,
        OP_BT1 = 4'd3,
        OP_BT2 = 4'd4,
        OP_BT4 = 4'd5,
        OP_MFD = 4'd6,
        OP_MTD = 4'd7,
        OP_MFS = 4'd8,
        OP_MTS = 4'd9,
        OP_MFP = 4'd10,
        OP_MTP = 4'd11,
        OP_MZ  = 4'd12,
        OP_MN  = 4'd13,
        OP_ALN = 4'd14,
        OP_NOP = 4'd15
    } fcc_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    localparam int WIN_W = 4;

endpackage

// File: rtl/fcc_window.sv
module fcc_window #(
    parameter int CC_W  = 8,
    parameter int IDX_W = 3,
    parameter int WIN   = 4
) (
    input  logic [CC_W-1:0]  cc_vec,
    input  logic [IDX_W-1:0] idx,
    output logic [WIN-1:0]   win
);
    localparam int PW = IDX_W + 2;

    for (genvar i = 0; i < WIN; i++) begin : g_bit
        logic [PW-1:0] pos;
        assign pos    = PW'(idx) + PW'(i);
        // flags past the top of the vector read as clear
        assign win[i] = (pos < PW'(CC_W)) ? cc_vec[pos[IDX_W-1:0]] : 1'b0;
    end

endmodule

// File: rtl/fcc_branch.sv
module fcc_branch
    import fcc_pkg::*;
#(
    parameter int WIN = 4
) (
    input  fcc_op_e        op,
    input  logic [WIN-1:0] win,
    output logic           taken
);
    logic [WIN-1:0] mask;
    logic           want_set;
    logic           is_br;

    always_comb begin
        mask     = '0;
        want_set = 1'b0;
        is_br    = 1'b1;
        unique case (op)
            OP_BF1: mask = WIN'(4'b0001);
            OP_BF2: mask = WIN'(4'b0011);
            OP_BF4: mask = WIN'(4'b1111);
            OP_BT1: begin mask = WIN'(4'b0001); want_set = 1'b1; end
            OP_BT2: begin mask = WIN'(4'b0011); want_set = 1'b1; end
            OP_BT4: begin mask = WIN'(4'b1111); want_set = 1'b1; end
            default: is_br = 1'b0;
        endcase
        if (!is_br)
            taken = 1'b0;
        else if (want_set)
            taken = |(win & mask);
        else
            taken = |(~win & mask);
    end

endmodule

// File: rtl/fcc_move.sv
module fcc_move
    import fcc_pkg::*;
#(
    parameter int HALF_W     = 32,
    parameter int GPR_W      = 64,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  fcc_op_e             op,
    input  logic [1:0]          win,
    input  logic [GPR_W-1:0]    gpr,
    input  logic [2*HALF_W-1:0] src_a,
    input  logic [2*HALF_W-1:0] src_b,
    input  logic [2*HALF_W-1:0] dst_old,
    output logic [2*HALF_W-1:0] wr_data
);
    localparam int DW = 2 * HALF_W;

    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi, d_lo, d_hi;
    logic              lo_en, hi_en, gpr_zero;
    logic [DW-1:0]     swizzle;

    assign a_lo     = src_a[HALF_W-1:0];
    assign a_hi     = src_a[DW-1:HALF_W];
    assign b_lo     = src_b[HALF_W-1:0];
    assign b_hi     = src_b[DW-1:HALF_W];
    assign d_lo     = dst_old[HALF_W-1:0];
    assign d_hi     = dst_old[DW-1:HALF_W];
    assign gpr_zero = (gpr == '0);

    if (BIG_ENDIAN) begin : g_big
        assign swizzle = {a_lo, b_hi};
    end else begin : g_little
        assign swizzle = {b_lo, a_hi};
    end

    always_comb begin
        lo_en = 1'b0;
        hi_en = 1'b0;
        unique case (op)
            OP_MFD: begin lo_en = ~win[0]; hi_en = ~win[0]; end
            OP_MTD: begin lo_en =  win[0]; hi_en =  win[0]; end
            OP_MFS: lo_en = ~win[0];
            OP_MTS: lo_en =  win[0];
            OP_MFP: begin lo_en = ~win[0]; hi_en = ~win[1]; end
            OP_MTP: begin lo_en =  win[0]; hi_en =  win[1]; end
            OP_MZ:  begin lo_en =  gpr_zero; hi_en =  gpr_zero; end
            OP_MN:  begin lo_en = ~gpr_zero; hi_en = ~gpr_zero; end
            default: ;
        endcase
        if (op == OP_ALN) begin
            unique case (gpr[2:0])
                3'd0:    wr_data = src_a;
                3'd4:    wr_data = swizzle;
                default: wr_data = dst_old;
            endcase
        end else begin
            wr_data = {hi_en ? a_hi : d_hi, lo_en ? a_lo : d_lo};
        end
    end

endmodule

// File: rtl/fcc_move_branch.sv
module fcc_move_branch
    import fcc_pkg::*;
#(
    parameter int HALF_W     = 32,
    parameter int CC_W       = 8,
    parameter int GPR_W      = 64,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [3:0]              op,
    input  logic [CC_W-1:0]         cc_vec,
    input  logic [$clog2(CC_W)-1:0] cc_idx,
    input  logic [GPR_W-1:0]        gpr,
    input  logic [2*HALF_W-1:0]     src_a,
    input  logic [2*HALF_W-1:0]     src_b,
    input  logic [2*HALF_W-1:0]     dst_old,
    output logic                    out_valid,
    output logic                    taken,
    output logic [2*HALF_W-1:0]     wr_data
);
    localparam int IDX_W = $clog2(CC_W);
    localparam int DW    = 2 * HALF_W;

    fcc_op_e       op_e;
    logic [WIN_W-1:0] win;
    logic          br_taken;
    logic [DW-1:0] mv_data;
    stage_e        state_q, state_d;

    assign op_e = fcc_op_e'(op);

    fcc_window #(.CC_W(CC_W), .IDX_W(IDX_W), .WIN(WIN_W)) u_win (
        .cc_vec (cc_vec),
        .idx    (cc_idx),
        .win    (win)
    );

    fcc_branch #(.WIN(WIN_W)) u_br (
        .op    (op_e),
        .win   (win),
        .taken (br_taken)
    );

    fcc_move #(.HALF_W(HALF_W), .GPR_W(GPR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_mv (
        .op      (op_e),
        .win     (win[1:0]),
        .gpr     (gpr),
        .src_a   (src_a),
        .src_b   (src_b),
        .dst_old (dst_old),
        .wr_data (mv_data)
    );

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            wr_data <= '0;
        end else if (in_valid) begin
            taken   <= br_taken;
            wr_data <= mv_data;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    AST_SINGLE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_BT1 |-> taken == $past(cc_vec[cc_idx])); // R1

    AST_MOVE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) >= OP_MFD |-> !taken); // R9

    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_MZ && $past(gpr) != '0 |-> wr_data == $past(dst_old)); // R6

    AST_ALIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_ALN && $past(gpr[2:0]) == 3'd0 |-> wr_data == $past(src_a)); // R7

    AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(op) == OP_MFS || $past(op) == OP_MTS)
        |-> wr_data[DW-1:HALF_W] == $past(dst_old[DW-1:HALF_W])); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid) |-> $stable(wr_data) && !out_valid); // R8

endmodule

// File: tb/sim_fcc_move_branch.sv
`timescale 1ns/1ps
module sim_fcc_move_branch;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [7:0]  cc;
        logic [2:0]  idx;
        logic [63:0] gpr;
        logic        exp_t;
        logic [63:0] exp_w;
    } vec_t;

    localparam logic [63:0] A = 64'hAAAAAAAA_11111111;
    localparam logic [63:0] B = 64'hBBBBBBBB_22222222;
    localparam logic [63:0] D = 64'hDDDDDDDD_33333333;
    localparam int N = 33;

    localparam vec_t VECS [N] = '{
        '{4'd1, 4'd0,  8'h04, 3'd2, 64'd0, 1'b0, D},                    // R1 false, bit set
        '{4'd1, 4'd3,  8'h04, 3'd2, 64'd0, 1'b1, D},                    // R1 true, bit set
        '{4'd1, 4'd0,  8'h04, 3'd1, 64'd0, 1'b1, D},                    // R1 false, bit clear
        '{4'd2, 4'd4,  8'h08, 3'd2, 64'd0, 1'b1, D},                    // R2 any2 true
        '{4'd2, 4'd1,  8'h0C, 3'd2, 64'd0, 1'b0, D},                    // R2 any2 false, both set
        '{4'd2, 4'd5,  8'h10, 3'd0, 64'd0, 1'b0, D},                    // R2 any4 true, outside
        '{4'd2, 4'd5,  8'h10, 3'd1, 64'd0, 1'b1, D},                    // R2 any4 true, top bit
        '{4'd2, 4'd2,  8'hFF, 3'd4, 64'd0, 1'b0, D},                    // R2 any4 false, all set
        '{4'd3, 4'd2,  8'hFF, 3'd6, 64'd0, 1'b1, D},                    // R3 missing bits clear
        '{4'd3, 4'd4,  8'h00, 3'd7, 64'd0, 1'b0, D},                    // R3
        '{4'd3, 4'd4,  8'h80, 3'd7, 64'd0, 1'b1, D},                    // R3
        '{4'd3, 4'd1,  8'h80, 3'd7, 64'd0, 1'b1, D},                    // R3
        '{4'd5, 4'd6,  8'h00, 3'd0, 64'd0, 1'b0, A},                    // R5
        '{4'd5, 4'd6,  8'h01, 3'd0, 64'd0, 1'b0, D},                    // R5
        '{4'd5, 4'd7,  8'h01, 3'd0, 64'd0, 1'b0, A},                    // R5
        '{4'd5, 4'd8,  8'h00, 3'd3, 64'd0, 1'b0, 64'hDDDDDDDD_11111111}, // R5 low only
        '{4'd5, 4'd9,  8'h00, 3'd3, 64'd0, 1'b0, D},                    // R5
        '{4'd4, 4'd11, 8'h02, 3'd1, 64'd0, 1'b0, 64'hDDDDDDDD_11111111}, // R4
        '{4'd4, 4'd11, 8'h04, 3'd1, 64'd0, 1'b0, 64'hAAAAAAAA_33333333}, // R4
        '{4'd4, 4'd10, 8'h04, 3'd1, 64'd0, 1'b0, 64'hDDDDDDDD_11111111}, // R4
        '{4'd3, 4'd11, 8'h80, 3'd7, 64'd0, 1'b0, 64'hDDDDDDDD_11111111}, // R3 paired top
        '{4'd3, 4'd10, 8'h80, 3'd7, 64'd0, 1'b0, 64'hAAAAAAAA_33333333}, // R3 paired top
        '{4'd6, 4'd12, 8'h00, 3'd0, 64'd0, 1'b0, A},                    // R6
        '{4'd6, 4'd12, 8'h00, 3'd0, 64'd1, 1'b0, D},                    // R6
        '{4'd6, 4'd13, 8'h00, 3'd0, 64'h80000000_00000000, 1'b0, A},    // R6
        '{4'd6, 4'd13, 8'h00, 3'd0, 64'd0, 1'b0, D},                    // R6
        '{4'd7, 4'd14, 8'h00, 3'd0, 64'd0, 1'b0, A},                    // R7
        '{4'd7, 4'd14, 8'h00, 3'd0, 64'd8, 1'b0, A},                    // R7
        '{4'd7, 4'd14, 8'h00, 3'd0, 64'd4, 1'b0, 64'h11111111_BBBBBBBB}, // R7 big endian
        '{4'd7, 4'd14, 8'h00, 3'd0, 64'd5, 1'b0, D},                    // R7
        '{4'd7, 4'd14, 8'h00, 3'd0, 64'd2, 1'b0, D},                    // R7
        '{4'd9, 4'd15, 8'hFF, 3'd0, 64'd0, 1'b0, D},                    // R9
        '{4'd9, 4'd7,  8'hFF, 3'd0, 64'd0, 1'b0, A}                     // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [7:0]  cc_vec = '0;
    logic [2:0]  cc_idx = '0;
    logic [63:0] gpr = '0;
    logic [63:0] src_a = A;
    logic [63:0] src_b = B;
    logic [63:0] dst_old = D;
    logic        out_valid, taken, le_valid, le_taken;
    logic [63:0] wr_data, le_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fcc_move_branch u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cc_vec(cc_vec),
        .cc_idx(cc_idx), .gpr(gpr), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .taken(taken), .wr_data(wr_data)
    );

    fcc_move_branch #(.BIG_ENDIAN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cc_vec(cc_vec),
        .cc_idx(cc_idx), .gpr(gpr), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(le_valid), .taken(le_taken), .wr_data(le_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", 64'(out_valid), 64'd0);
        check("R8 reset taken", 64'(taken), 64'd0);
        check("R8 reset wr_data", wr_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle out_valid", 64'(out_valid), 64'd0);

        for (int i = 0; i < N; i++) begin
            in_valid = 1'b1;
            op       = VECS[i].op;
            cc_vec   = VECS[i].cc;
            cc_idx   = VECS[i].idx;
            gpr      = VECS[i].gpr;
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b1 || taken !== VECS[i].exp_t || wr_data !== VECS[i].exp_w) begin
                fails++;
                $display("FAIL R%0d vec %0d actual=%b/%b/%h expected=1/%b/%h", VECS[i].req, i,
                         out_valid, taken, wr_data, VECS[i].exp_t, VECS[i].exp_w);
            end
        end

        // R7 little-endian variant
        op = 4'd14; gpr = 64'd4;
        @(negedge clk);
        check("R7 little endian align", le_data, 64'h22222222_AAAAAAAA);

        // R8 drop of in_valid: valid falls, data holds
        op = 4'd12; gpr = 64'd0; in_valid = 1'b1;
        @(negedge clk);
        check("R8 latched data", wr_data, A);
        in_valid = 1'b0; gpr = 64'd1; op = 4'd7; cc_vec = 8'h00;
        @(negedge clk);
        check("R8 out_valid falls", 64'(out_valid), 64'd0);
        check("R8 data held", wr_data, A);
        @(negedge clk);
        check("R8 data still held", wr_data, A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule